// File: doc/BRIEF.md
# MDIO Management Slave

This block is the serial management slave of a PHY-style device. It samples the shared MDIO line on each rising edge of MDC and decodes read and write frames addressed to its own 5-bit PHY address. A matching frame becomes one access on a 32-entry by 16-bit register bus toward a register block, marked by a single-cycle read or write strobe. On a read, the slave takes over the line through a tri-state enable for the second turnaround bit and the sixteen data bits. At all other times it leaves the line to the external pull-up.

After a hardware reset the slave stays deaf until it has seen a run of 32 high bits, which synchronises it to the management bus. From then on a single high idle bit between frames is enough, so a station manager may suppress later preambles. The PHY address is taken from strap pins while reset is held. Two control bits live inside the block: a loopback enable and a self-clearing soft-reset bit, both in register 0x00. The latched address can be read back from register 0x19.

Top module: `mgmt_serial_slave`

## Requirements
- R1: After a hardware reset, every frame is ignored (no strobe, MDIO never driven) until at least 32 consecutive high bits have been sampled on MDIO; a run of only 31 ones followed by a zero does not synchronise.
- R2: Once synchronised, a frame is accepted when it follows a single sampled high idle bit, with no further preamble.
- R3: A frame is 32 bits, sent MSB first: start bits 0 then 1, opcode 10 (read) or 01 (write), a 5-bit PHY address, a 5-bit register address, two turnaround bits, then 16 data bits.
- R4: The PHY address is loaded from `strap_phy_addr` while reset is held. Register 0x19 reads it in bits [4:0] with bits [15:5] zero, and a write to 0x19 leaves it unchanged.
- R5: For a valid read, `reg_rd_o` is high for exactly the first turnaround bit period, with `reg_addr_o` holding the register address, and MDIO is released in that period.
- R6: For a valid read, the slave drives 0 during the second turnaround bit and then the 16 data bits MSB first. Each bit changes just after a rising MDC edge. The line is released again in the bit period after the last data bit.
- R7: For a valid write, `reg_wr_o` is high for the one bit period after the last data bit, with `reg_addr_o` and `reg_wdata_o` holding the register address and the 16 data bits.
- R8: A frame whose PHY address differs from the latched one, whose start bits are not 01, or whose opcode is 00 or 11 produces no strobe and no drive. The whole 32-bit frame is skipped before the slave looks for a new start.
- R9: Bit 14 of register 0x00 is the loopback enable. It drives `loopback_o`, reads back in bit 14 with the other bits 0, and takes a written value on the MDC edge that ends the write strobe.
- R10: Writing 1 to bit 15 of register 0x00 pulses `soft_rst_o` together with the write strobe and clears loopback whatever bit 14 held. Bit 15 reads as 0. The latched PHY address and the synchronised state are kept.
- R11: A read of any register other than 0x00 and 0x19 returns `reg_rdata_i` as presented during the read strobe cycle.
- R12: During and right after reset, MDIO is released, both strobes and `soft_rst_o` are low, and loopback is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock; all sampling and updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| strap_phy_addr | input | 5 | PHY address straps, loaded while reset is held |
| mdio_i | input | 1 | Resolved level of the MDIO line |
| mdio_o | output | 1 | Value driven onto MDIO when enabled |
| mdio_oe | output | 1 | Tri-state enable for MDIO, high while driving |
| reg_addr_o | output | 5 | Register address of the current access |
| reg_wdata_o | output | 16 | Write data toward the register block |
| reg_wr_o | output | 1 | Single-cycle write strobe |
| reg_rd_o | output | 1 | Single-cycle read strobe |
| reg_rdata_i | input | 16 | Read data from the register block, valid during the read strobe |
| loopback_o | output | 1 | Loopback enable from register 0x00 bit 14 |
| soft_rst_o | output | 1 | Soft-reset pulse toward the register block |

## Verification
Timing is counted in bit periods from the first start bit, period k lying between the rising edges that sample bits k-1 and k. The read strobe is due in period 14. The turnaround zero is due in period 15 and read data in periods 16 to 31. The write strobe and soft-reset pulse are due in period 32, and loopback_o changes from period 33. The bench drives and samples only on falling MDC edges, records each output in the period where it is due and compares with those fixed positions. This covers full sweeps over every register address and every non-matching PHY address.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_TURN,
    ST_DATA,
    ST_SKIP
  } frm_state_e;

  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_WRITE = 2'b01;

endpackage

// File: rtl/mgmt_rst_sync.sv
module mgmt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_n_sync = stage_q[1];

endmodule

// File: rtl/mgmt_sync_tracker.sv
module mgmt_sync_tracker #(
  parameter int unsigned PREAMBLE_LEN = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mdio_i,
  output logic synced_o
);

  localparam int unsigned CNT_W = $clog2(PREAMBLE_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PREAMBLE_LEN - 1);

  logic [CNT_W-1:0] ones_q, ones_d;
  logic             synced_q, synced_d;
  logic             cnt_en;

  // counting stops once synchronisation is reached
  assign cnt_en = !synced_q;

  always_comb begin
    ones_d   = ones_q;
    synced_d = synced_q;
    if (mdio_i) begin
      if (ones_q == CNT_LAST) begin
        synced_d = 1'b1;
      end else begin
        ones_d = ones_q + CNT_W'(1);
      end
    end else begin
      ones_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ones_q   <= '0;
      synced_q <= 1'b0;
    end else if (cnt_en) begin
      ones_q   <= ones_d;
      synced_q <= synced_d;
    end
  end

  assign synced_o = synced_q;

endmodule

// File: rtl/mgmt_frame_engine.sv
module mgmt_frame_engine
  import mgmt_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mdio_i,
  input  logic              synced_i,
  input  logic [ADDR_W-1:0] phy_addr_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_data_o,
  output logic              rd_stb_o,
  output logic              wr_stb_o
);

  // header = second start bit, opcode, PHY address, register address
  localparam int unsigned HDR_W      = 3 + 2 * ADDR_W;
  localparam int unsigned FRAME_BITS = 1 + HDR_W + 2 + DATA_W;
  localparam int unsigned IDX_W      = $clog2(FRAME_BITS);
  localparam logic [IDX_W-1:0] HDR_LAST = IDX_W'(HDR_W);
  localparam logic [IDX_W-1:0] TA_FIRST = IDX_W'(HDR_W + 1);
  localparam logic [IDX_W-1:0] BIT_LAST = IDX_W'(FRAME_BITS - 1);

  frm_state_e        state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              idle_q, idle_d;
  logic [HDR_W-2:0]  hdr_q, hdr_d;
  logic              is_rd_q, is_rd_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              rd_stb_q, rd_stb_d;
  logic              wr_stb_q, wr_stb_d;
  logic              oe_q, oe_d;
  logic              out_q, out_d;

  logic [HDR_W-1:0]  hdr_full;
  logic              start_ok;
  logic [1:0]        opcode;
  logic [ADDR_W-1:0] pa_field;
  logic [ADDR_W-1:0] ra_field;
  logic              addr_hit;

  assign hdr_full = {hdr_q, mdio_i};
  assign start_ok = hdr_full[HDR_W-1];
  assign opcode   = hdr_full[HDR_W-2 -: 2];
  assign pa_field = hdr_full[2*ADDR_W-1 -: ADDR_W];
  assign ra_field = hdr_full[ADDR_W-1:0];
  assign addr_hit = start_ok && (pa_field == phy_addr_i);

  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    idle_d   = idle_q;
    hdr_d    = hdr_q;
    is_rd_d  = is_rd_q;
    addr_d   = addr_q;
    sh_d     = sh_q;
    oe_d     = oe_q;
    out_d    = out_q;
    rd_stb_d = 1'b0;
    wr_stb_d = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (mdio_i) begin
          idle_d = 1'b1;
        end else if (synced_i && idle_q) begin
          state_d = ST_HDR;
          idx_d   = IDX_W'(1);
          idle_d  = 1'b0;
        end
      end
      ST_HDR: begin
        hdr_d = hdr_full[HDR_W-2:0];
        idx_d = idx_q + IDX_W'(1);
        if (idx_q == HDR_LAST) begin
          if (addr_hit && opcode == OP_READ) begin
            state_d  = ST_TURN;
            is_rd_d  = 1'b1;
            rd_stb_d = 1'b1;
            addr_d   = ra_field;
          end else if (addr_hit && opcode == OP_WRITE) begin
            state_d = ST_TURN;
            is_rd_d = 1'b0;
            addr_d  = ra_field;
          end else begin
            state_d = ST_SKIP;
          end
        end
      end
      ST_TURN: begin
        idx_d = idx_q + IDX_W'(1);
        if (idx_q == TA_FIRST) begin
          if (is_rd_q) begin
            sh_d  = rdata_i;
            oe_d  = 1'b1;
            out_d = 1'b0;
          end
        end else begin
          state_d = ST_DATA;
          if (is_rd_q) begin
            out_d = sh_q[DATA_W-1];
            sh_d  = {sh_q[DATA_W-2:0], 1'b0};
          end
        end
      end
      ST_DATA: begin
        idx_d = idx_q + IDX_W'(1);
        if (is_rd_q) begin
          if (idx_q == BIT_LAST) begin
            oe_d  = 1'b0;
            out_d = 1'b0;
          end else begin
            out_d = sh_q[DATA_W-1];
            sh_d  = {sh_q[DATA_W-2:0], 1'b0};
          end
        end else begin
          sh_d = {sh_q[DATA_W-2:0], mdio_i};
        end
        if (idx_q == BIT_LAST) begin
          state_d  = ST_IDLE;
          idx_d    = '0;
          wr_stb_d = !is_rd_q;
        end
      end
      ST_SKIP: begin
        idx_d = idx_q + IDX_W'(1);
        if (idx_q == BIT_LAST) begin
          state_d = ST_IDLE;
          idx_d   = '0;
        end
      end
      default: begin
        state_d = ST_IDLE;
        idx_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      idle_q   <= 1'b0;
      hdr_q    <= '0;
      is_rd_q  <= 1'b0;
      addr_q   <= '0;
      sh_q     <= '0;
      rd_stb_q <= 1'b0;
      wr_stb_q <= 1'b0;
      oe_q     <= 1'b0;
      out_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      idx_q    <= idx_d;
      idle_q   <= idle_d;
      hdr_q    <= hdr_d;
      is_rd_q  <= is_rd_d;
      addr_q   <= addr_d;
      sh_q     <= sh_d;
      rd_stb_q <= rd_stb_d;
      wr_stb_q <= wr_stb_d;
      oe_q     <= oe_d;
      out_q    <= out_d;
    end
  end

  assign mdio_o     = out_q;
  assign mdio_oe    = oe_q;
  assign reg_addr_o = addr_q;
  assign reg_data_o = sh_q;
  assign rd_stb_o   = rd_stb_q;
  assign wr_stb_o   = wr_stb_q;

endmodule

// File: rtl/mgmt_ctrl_regs.sv
module mgmt_ctrl_regs #(
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned CTRL_ADDR = 0,
  parameter int unsigned ID_ADDR   = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] strap_i,
  input  logic              wr_stb_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_rst_bit_i,
  input  logic              wr_lpbk_bit_i,
  input  logic [DATA_W-1:0] ext_rdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] phy_addr_o,
  output logic              loopback_o,
  output logic              soft_rst_o
);

  localparam int unsigned LPBK_BIT = DATA_W - 2;

  logic [ADDR_W-1:0] phy_addr_q;
  logic              lpbk_q, lpbk_d;
  logic              ctrl_hit, id_hit, ctrl_wr;

  assign ctrl_hit = (addr_i == ADDR_W'(CTRL_ADDR));
  assign id_hit   = (addr_i == ADDR_W'(ID_ADDR));
  assign ctrl_wr  = wr_stb_i && ctrl_hit;

  // strap latch: follows the straps while reset is held, frozen afterwards
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phy_addr_q <= strap_i;
    end else begin
      phy_addr_q <= phy_addr_q;
    end
  end

  always_comb begin
    lpbk_d = lpbk_q;
    if (ctrl_wr) begin
      lpbk_d = wr_rst_bit_i ? 1'b0 : wr_lpbk_bit_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lpbk_q <= 1'b0;
    end else if (ctrl_wr) begin
      lpbk_q <= lpbk_d;
    end
  end

  always_comb begin
    rdata_o = ext_rdata_i;
    if (ctrl_hit) begin
      rdata_o           = '0;
      rdata_o[LPBK_BIT] = lpbk_q;
    end else if (id_hit) begin
      rdata_o = DATA_W'(phy_addr_q);
    end
  end

  assign soft_rst_o = ctrl_wr && wr_rst_bit_i;
  assign phy_addr_o = phy_addr_q;
  assign loopback_o = lpbk_q;

endmodule

// File: rtl/mgmt_serial_slave.sv
module mgmt_serial_slave #(
  parameter int unsigned ADDR_W       = 5,
  parameter int unsigned DATA_W       = 16,
  parameter int unsigned PREAMBLE_LEN = 32,
  parameter int unsigned CTRL_ADDR    = 0,
  parameter int unsigned ID_ADDR      = 25
) (
  input  logic              mdc,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] strap_phy_addr,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              reg_wr_o,
  output logic              reg_rd_o,
  input  logic [DATA_W-1:0] reg_rdata_i,
  output logic              loopback_o,
  output logic              soft_rst_o
);

  logic              rst_n_sync;
  logic              synced;
  logic [ADDR_W-1:0] phy_addr;
  logic [DATA_W-1:0] rdata_mux;

  mgmt_rst_sync u_rst_sync (
    .clk        (mdc),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  mgmt_sync_tracker #(
    .PREAMBLE_LEN (PREAMBLE_LEN)
  ) u_sync (
    .clk      (mdc),
    .rst_n    (rst_n_sync),
    .mdio_i   (mdio_i),
    .synced_o (synced)
  );

  mgmt_frame_engine #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_engine (
    .clk        (mdc),
    .rst_n      (rst_n_sync),
    .mdio_i     (mdio_i),
    .synced_i   (synced),
    .phy_addr_i (phy_addr),
    .rdata_i    (rdata_mux),
    .mdio_o     (mdio_o),
    .mdio_oe    (mdio_oe),
    .reg_addr_o (reg_addr_o),
    .reg_data_o (reg_wdata_o),
    .rd_stb_o   (reg_rd_o),
    .wr_stb_o   (reg_wr_o)
  );

  mgmt_ctrl_regs #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .CTRL_ADDR (CTRL_ADDR),
    .ID_ADDR   (ID_ADDR)
  ) u_ctrl (
    .clk           (mdc),
    .rst_n         (rst_n_sync),
    .strap_i       (strap_phy_addr),
    .wr_stb_i      (reg_wr_o),
    .addr_i        (reg_addr_o),
    .wr_rst_bit_i  (reg_wdata_o[DATA_W-1]),
    .wr_lpbk_bit_i (reg_wdata_o[DATA_W-2]),
    .ext_rdata_i   (reg_rdata_i),
    .rdata_o       (rdata_mux),
    .phy_addr_o    (phy_addr),
    .loopback_o    (loopback_o),
    .soft_rst_o    (soft_rst_o)
  );

endmodule

// File: rtl/mgmt_serial_slave_chk.sv
module mgmt_serial_slave_chk (
  input logic mdc,
  input logic rst_n,
  input logic mdio_o,
  input logic mdio_oe,
  input logic reg_rd_o,
  input logic reg_wr_o,
  input logic loopback_o,
  input logic soft_rst_o
);

  // R6
  ta_zero_chk: assert property (@(posedge mdc) disable iff (!rst_n)
    $rose(mdio_oe) |-> (!mdio_o && $past(reg_rd_o)));

  // R6
  rd_then_drive_chk: assert property (@(posedge mdc) disable iff (!rst_n)
    reg_rd_o |=> (mdio_oe && !mdio_o));

  // R5
  rd_pulse_chk: assert property (@(posedge mdc) disable iff (!rst_n)
    reg_rd_o |=> !reg_rd_o);

  // R7
  wr_pulse_chk: assert property (@(posedge mdc) disable iff (!rst_n)
    reg_wr_o |=> !reg_wr_o);

  // R7
  strobe_excl_chk: assert property (@(posedge mdc) disable iff (!rst_n)
    !(reg_rd_o && reg_wr_o));

  // R9
  lpbk_wr_only_chk: assert property (@(posedge mdc) disable iff (!rst_n)
    !$stable(loopback_o) |-> $past(reg_wr_o));

  // R10
  srst_clear_chk: assert property (@(posedge mdc) disable iff (!rst_n)
    soft_rst_o |=> !loopback_o);

  // R10
  srst_strobe_chk: assert property (@(posedge mdc) disable iff (!rst_n)
    soft_rst_o |-> reg_wr_o);

endmodule

bind mgmt_serial_slave mgmt_serial_slave_chk u_chk (
  .mdc        (mdc),
  .rst_n      (rst_n),
  .mdio_o     (mdio_o),
  .mdio_oe    (mdio_oe),
  .reg_rd_o   (reg_rd_o),
  .reg_wr_o   (reg_wr_o),
  .loopback_o (loopback_o),
  .soft_rst_o (soft_rst_o)
);

// File: tb/mgmt_serial_slave_bench.sv
module mgmt_serial_slave_bench;

  logic        mdc = 1'b0;
  logic        rst_n;
  logic [4:0]  strap;
  logic        mst_d;
  logic        mdio_i;
  logic        mdio_o, mdio_oe;
  logic [4:0]  reg_addr_o;
  logic [15:0] reg_wdata_o, reg_rdata_i;
  logic        reg_wr_o, reg_rd_o, loopback_o, soft_rst_o;

  always #2 mdc = ~mdc;

  assign mdio_i      = mdio_oe ? mdio_o : mst_d;
  assign reg_rdata_i = {reg_addr_o, ~reg_addr_o, reg_addr_o, 1'b1};

  mgmt_serial_slave u_mgmt_serial_slave (
    .mdc            (mdc),
    .rst_n          (rst_n),
    .strap_phy_addr (strap),
    .mdio_i         (mdio_i),
    .mdio_o         (mdio_o),
    .mdio_oe        (mdio_oe),
    .reg_addr_o     (reg_addr_o),
    .reg_wdata_o    (reg_wdata_o),
    .reg_wr_o       (reg_wr_o),
    .reg_rd_o       (reg_rd_o),
    .reg_rdata_i    (reg_rdata_i),
    .loopback_o     (loopback_o),
    .soft_rst_o     (soft_rst_o)
  );

  int checks = 0;
  int errors = 0;
  logic lpbk_m;

  int          o_oe, o_rd, o_wr, o_srst, o_rd_per, o_wr_per;
  logic [4:0]  o_rd_addr, o_wr_addr;
  logic [15:0] o_wr_data, o_rdata;
  logic        o_ta1_oe, o_ta2_oe, o_ta2_val, o_end_oe;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_rd(input logic [4:0] a);
    if (a == 5'h00) return {1'b0, lpbk_m, 14'h0};
    if (a == 5'h19) return {11'h0, strap};
    return {a, ~a, a, 1'b1};
  endfunction

  task automatic observe(input int k);
    if (mdio_oe) o_oe++;
    if (reg_rd_o) begin o_rd++; o_rd_addr = reg_addr_o; o_rd_per = k; end
    if (reg_wr_o) begin o_wr++; o_wr_addr = reg_addr_o; o_wr_data = reg_wdata_o; o_wr_per = k; end
    if (soft_rst_o) o_srst++;
    if (k == 14) o_ta1_oe = mdio_oe;
    if (k == 15) begin o_ta2_oe = mdio_oe; o_ta2_val = mdio_o; end
    if (k >= 16 && k <= 31) o_rdata[31-k] = mdio_o;
    if (k == 32) o_end_oe = mdio_oe;
  endtask

  // one 32-bit frame followed by one idle bit; period k observed at falling edge k
  task automatic run_frame(input logic [1:0] st, input logic [1:0] op,
                           input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] wd);
    logic [31:0] f;
    f = {st, op, pa, ra, (op == 2'b10) ? 2'b11 : 2'b10, (op == 2'b10) ? 16'hFFFF : wd};
    o_oe = 0; o_rd = 0; o_wr = 0; o_srst = 0; o_rd_per = -1; o_wr_per = -1;
    o_rdata = '0; o_ta1_oe = 1'b1; o_ta2_oe = 1'b0; o_ta2_val = 1'b1; o_end_oe = 1'b1;
    for (int i = 0; i < 33; i++) begin
      @(negedge mdc);
      observe(i);
      mst_d = (i < 32) ? f[31-i] : 1'b1;
    end
  endtask

  task automatic send_level(input logic v, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge mdc);
      mst_d = v;
    end
  endtask

  task automatic hw_reset(input logic [4:0] s);
    strap = s;
    mst_d = 1'b0;
    @(negedge mdc);
    rst_n = 1'b0;
    repeat (3) @(negedge mdc);
    chk("R12", "oe in reset", int'(mdio_oe), 0);
    chk("R12", "strobes in reset", int'({reg_rd_o, reg_wr_o, soft_rst_o}), 0);
    chk("R12", "loopback in reset", int'(loopback_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge mdc);
    lpbk_m = 1'b0;
  endtask

  task automatic read_ok(input logic [4:0] ra, input string tag);
    run_frame(2'b01, 2'b10, strap, ra, 16'h0);
    chk(tag, "read strobe count", o_rd, 1);
    chk(tag, "read addr", int'(o_rd_addr), int'(ra));
    chk(tag, "read data", int'(o_rdata), int'(exp_rd(ra)));
  endtask

  task automatic write_ok(input logic [4:0] ra, input logic [15:0] wd);
    run_frame(2'b01, 2'b01, strap, ra, wd);
    chk("R7", "write strobe count", o_wr, 1);
    chk("R7", "write strobe period", o_wr_per, 32);
    chk("R7", "write addr", int'(o_wr_addr), int'(ra));
    chk("R7", "write data", int'(o_wr_data), int'(wd));
    chk("R7", "no drive on write", o_oe, 0);
  endtask

  initial begin
    repeat (100000) @(posedge mdc);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b1;
    lpbk_m = 1'b0;
    hw_reset(5'h0B);

    // R1: 31 ones do not synchronise
    send_level(1'b1, 31);
    run_frame(2'b01, 2'b10, strap, 5'h19, 16'h0);
    chk("R1", "no read strobe before sync", o_rd, 0);
    chk("R1", "no drive before sync", o_oe, 0);
    send_level(1'b0, 1);
    send_level(1'b1, 31);
    run_frame(2'b01, 2'b01, strap, 5'h00, 16'h4000);
    chk("R1", "no write strobe before sync", o_wr, 0);
    @(negedge mdc);
    chk("R1", "loopback untouched before sync", int'(loopback_o), 0);
    send_level(1'b0, 1);
    send_level(1'b1, 32);

    // R4, R5, R6 on the first synchronised read
    read_ok(5'h19, "R4");
    chk("R5", "read strobe period", o_rd_per, 14);
    chk("R5", "released in first turnaround", int'(o_ta1_oe), 0);
    chk("R6", "drive in second turnaround", int'(o_ta2_oe), 1);
    chk("R6", "zero in second turnaround", int'(o_ta2_val), 0);
    chk("R6", "drive periods", o_oe, 17);
    chk("R6", "released after data", int'(o_end_oe), 0);

    // R2, R3, R11: every register, one idle bit between frames
    for (int a = 0; a < 32; a++) begin
      read_ok(5'(a), (a == 0 || a == 25) ? "R3" : "R11");
      chk("R2", "drive periods per read", o_oe, 17);
    end

    // R7: writes to every register except the control register
    for (int a = 1; a < 32; a++) begin
      write_ok(5'(a), 16'(a * 16'h0813) ^ 16'hA5A5);
    end
    read_ok(5'h19, "R4");

    // R9: loopback
    write_ok(5'h00, 16'h4000);
    lpbk_m = 1'b1;
    @(negedge mdc);
    chk("R9", "loopback set", int'(loopback_o), 1);
    read_ok(5'h00, "R9");
    write_ok(5'h00, 16'h3FFF);
    lpbk_m = 1'b0;
    @(negedge mdc);
    chk("R9", "loopback cleared", int'(loopback_o), 0);
    read_ok(5'h00, "R9");
    write_ok(5'h00, 16'h4000);
    lpbk_m = 1'b1;

    // R10: self-clearing reset bit
    write_ok(5'h00, 16'hC000);
    chk("R10", "soft reset pulse count", o_srst, 1);
    lpbk_m = 1'b0;
    @(negedge mdc);
    chk("R10", "loopback after soft reset", int'(loopback_o), 0);
    read_ok(5'h00, "R10");
    read_ok(5'h19, "R10");

    // R8: every other PHY address
    for (int p = 0; p < 32; p++) begin
      if (5'(p) != strap) begin
        run_frame(2'b01, 2'b10, 5'(p), 5'h19, 16'h0);
        chk("R8", "no read strobe on other addr", o_rd, 0);
        chk("R8", "no drive on other addr", o_oe, 0);
        run_frame(2'b01, 2'b01, 5'(p), 5'h00, 16'h4000);
        chk("R8", "no write strobe on other addr", o_wr, 0);
      end
    end
    @(negedge mdc);
    chk("R8", "loopback untouched", int'(loopback_o), 0);

    // R8: bad start and bad opcodes
    run_frame(2'b00, 2'b10, strap, 5'h19, 16'h0);
    chk("R8", "bad start no strobe", o_rd + o_wr + o_oe, 0);
    read_ok(5'h19, "R8");
    run_frame(2'b01, 2'b00, strap, 5'h00, 16'h4000);
    chk("R8", "opcode 00 no strobe", o_rd + o_wr + o_oe, 0);
    read_ok(5'h00, "R8");
    run_frame(2'b01, 2'b11, strap, 5'h00, 16'h4000);
    chk("R8", "opcode 11 no strobe", o_rd + o_wr + o_oe, 0);
    read_ok(5'h00, "R8");

    // R1, R4: new straps after a second hardware reset
    hw_reset(5'h1F);
    send_level(1'b1, 2);
    run_frame(2'b01, 2'b10, strap, 5'h19, 16'h0);
    chk("R1", "no read after reset without preamble", o_rd + o_oe, 0);
    send_level(1'b1, 32);
    read_ok(5'h19, "R4");
    read_ok(5'h00, "R12");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule